// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR flash. After software or another engine has issued a program or erase command, the host pulses `start`. The poller then reads status bytes from an address inside the sector under work until it can decide whether the embedded operation succeeded. Each access is a request/acknowledge handshake on a simple byte bus. Generating strobes and bus timing is left to the bus agent behind that handshake.

Two decision methods are available, and `use_toggle` selects one per run. In toggle mode, the block compares the toggling status bit across back-to-back reads. In data-polling mode, it compares the polling status bit against the value it expects. In both methods, a raised error bit does not end the run at once. The bit can rise in the same read in which the device finishes, so the poller rechecks before it reports failure.

On success, the block does one more plain read so that the whole byte is valid, and it presents that byte with `done`. On failure, it writes the reset command so that the device returns to array reads. A per-run budget of reads bounds the wait.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held low, and after its release, `done`, `pass`, `fail` and `bus_req` are all 0.
- R2: Once `bus_req` rises, it stays high with `bus_addr` and `bus_we` stable until a cycle with `bus_ack` high. Every access of a run targets the `target_addr` latched at `start`.
- R3: Toggle mode (`use_toggle`=1): if bit 6 of two consecutive reads is equal, the result is pass.
- R4: Toggle mode: if bit 6 differs between consecutive reads and bit 5 of the newer read is 0, polling continues. The newer read becomes the reference for the next comparison.
- R5: Toggle mode: if bit 6 differs and bit 5 of the newer read is 1, the poller takes a fresh pair of reads. Equal bit 6 in that pair gives pass, and unequal bit 6 gives fail.
- R6: Data-polling mode (`use_toggle`=0): a read whose bit 7 equals the expected bit gives pass. The expected bit is `expect_data[7]` when `is_erase`=0, and 1 when `is_erase`=1, whatever `expect_data` holds.
- R7: Data-polling mode: after a bit-7 mismatch with bit 5 set to 1, exactly one more read decides. A match gives pass and a mismatch gives fail.
- R8: On pass, one further read is made, and its byte appears on `final_data` when `done` rises.
- R9: On fail, a single write of 0xF0 to the target address is made (`bus_we`=1) before `done` rises.
- R10: If the run is still undecided after `max_polls` status reads (at least one read is always made), the result is fail, and the R9 reset write follows.
- R11: `done` is a one-cycle pulse. At that pulse exactly one of `pass`/`fail` is 1, and it holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll run; sampled only when idle |
| use_toggle | input | 1 | 1 = toggle-bit method, 0 = data-polling method |
| is_erase | input | 1 | Operation under poll is an erase (expected polling bit is 1) |
| expect_data | input | DATA_W | Byte that was programmed (used in data-polling mode) |
| target_addr | input | ADDR_W | Address inside the sector being programmed or erased |
| max_polls | input | CNT_W | Status-read budget per run |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data (reset command) |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| final_data | output | DATA_W | Array byte read after a pass |

## Verification
The bench scripts the status bytes the flash returns, one sequence per run. In toggle mode the sequences cover:
- an immediately steady bit 6, for pass on the first pair;
- a toggling bit 6 with the error bit clear, to show that polling continues and that the reference byte advances;
- a toggling bit 6 with the error bit set, followed by a steady pair and, in another run, a still-toggling pair. These separate the late-finish pass from a real failure.

In data-polling mode the sequences cover:
- a delayed match;
- an erase run in which `expect_data` would match the wrong polling value;
- an error-flagged mismatch followed by a match, and in another run by a further mismatch.

Budget runs in both modes feed bytes that never resolve. Read counts, the reset write and the final byte tell each path apart.

// File: rtl/flpoll_pkg.sv
package flpoll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_POLL,
      ST_FINAL,
      ST_RESET
   } fp_state_t;

   typedef enum logic [1:0] {
      V_CONT,
      V_RECHK,
      V_PASS,
      V_FAIL
   } fp_verdict_t;

endpackage

// File: rtl/flpoll_judge.sv
module flpoll_judge
   import flpoll_pkg::*;
(
   input  logic        use_tgl,
   input  logic        exp_bit,
   input  logic        have_prev,
   input  logic        prev_tgl,
   input  logic        recheck,
   input  logic        poll_bit,
   input  logic        tgl_bit,
   input  logic        err_bit,
   output fp_verdict_t verdict
);

   fp_verdict_t v_tgl;
   fp_verdict_t v_dat;

   // toggle method: needs a reference read before any comparison
   always_comb begin
      if (!have_prev)                v_tgl = V_CONT;
      else if (tgl_bit == prev_tgl)  v_tgl = V_PASS;
      else if (recheck)              v_tgl = V_FAIL;
      else if (err_bit)              v_tgl = V_RECHK;
      else                           v_tgl = V_CONT;
   end

   // data-polling method: every read is judged on its own
   always_comb begin
      if (poll_bit == exp_bit)       v_dat = V_PASS;
      else if (recheck)              v_dat = V_FAIL;
      else if (err_bit)              v_dat = V_RECHK;
      else                           v_dat = V_CONT;
   end

   assign verdict = use_tgl ? v_tgl : v_dat;

endmodule

// File: rtl/flpoll_budget.sv
module flpoll_budget #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             last
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   // the read being acknowledged now is number cnt_q+1
   assign last = ({1'b0, cnt_q} + (CNT_W + 1)'(1)) >= {1'b0, limit};

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
   import flpoll_pkg::*;
#(
   parameter int          ADDR_W    = 19,
   parameter int          DATA_W    = 8,
   parameter int          CNT_W     = 16,
   parameter int          POLL_BIT  = 7,
   parameter int          TGL_BIT   = 6,
   parameter int          ERR_BIT   = 5,
   parameter int unsigned RESET_CMD = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              use_toggle,
   input  logic              is_erase,
   input  logic [DATA_W-1:0] expect_data,
   input  logic [ADDR_W-1:0] target_addr,
   input  logic [CNT_W-1:0]  max_polls,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic [DATA_W-1:0] final_data
);

   localparam logic [DATA_W-1:0] RST_WORD = DATA_W'(RESET_CMD);

   if (POLL_BIT >= DATA_W || TGL_BIT >= DATA_W || ERR_BIT >= DATA_W) begin : g_bad_bits
      $error("status bit position outside data width");
   end
   if (POLL_BIT == TGL_BIT || POLL_BIT == ERR_BIT || TGL_BIT == ERR_BIT) begin : g_bad_overlap
      $error("status bit positions must be distinct");
   end
   if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("counter and address widths must be positive");
   end

   fp_state_t         state_q;
   fp_verdict_t       verdict;
   logic [ADDR_W-1:0] addr_q;
   logic              tgl_q;
   logic              exp_q;
   logic [CNT_W-1:0]  max_q;
   logic              have_prev_q;
   logic              prev_tgl_q;
   logic              recheck_q;
   logic              done_q;
   logic              pass_q;
   logic              fail_q;
   logic [DATA_W-1:0] final_q;
   logic              budget_last;
   logic              launch;
   logic              poll_ack;

   assign launch   = (state_q == ST_IDLE) && start;
   assign poll_ack = (state_q == ST_POLL) && bus_ack;

   flpoll_judge u_judge (
      .use_tgl   (tgl_q),
      .exp_bit   (exp_q),
      .have_prev (have_prev_q),
      .prev_tgl  (prev_tgl_q),
      .recheck   (recheck_q),
      .poll_bit  (bus_rdata[POLL_BIT]),
      .tgl_bit   (bus_rdata[TGL_BIT]),
      .err_bit   (bus_rdata[ERR_BIT]),
      .verdict   (verdict)
   );

   flpoll_budget #(.CNT_W(CNT_W)) u_budget (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .inc   (poll_ack),
      .limit (max_q),
      .last  (budget_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         tgl_q       <= 1'b0;
         exp_q       <= 1'b0;
         max_q       <= '0;
         have_prev_q <= 1'b0;
         prev_tgl_q  <= 1'b0;
         recheck_q   <= 1'b0;
         done_q      <= 1'b0;
         pass_q      <= 1'b0;
         fail_q      <= 1'b0;
         final_q     <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q      <= target_addr;
                  tgl_q       <= use_toggle;
                  exp_q       <= is_erase | expect_data[POLL_BIT];
                  max_q       <= max_polls;
                  have_prev_q <= 1'b0;
                  recheck_q   <= 1'b0;
                  pass_q      <= 1'b0;
                  fail_q      <= 1'b0;
                  state_q     <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (bus_ack) begin
                  case (verdict)
                     V_PASS: state_q <= ST_FINAL;
                     V_FAIL: state_q <= ST_RESET;
                     V_RECHK: begin
                        recheck_q   <= 1'b1;
                        have_prev_q <= 1'b0;
                        if (budget_last) state_q <= ST_RESET;
                     end
                     default: begin
                        have_prev_q <= 1'b1;
                        prev_tgl_q  <= bus_rdata[TGL_BIT];
                        if (budget_last) state_q <= ST_RESET;
                     end
                  endcase
               end
            end
            ST_FINAL: begin
               if (bus_ack) begin
                  final_q <= bus_rdata;
                  pass_q  <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               if (bus_ack) begin
                  fail_q  <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign bus_req    = (state_q != ST_IDLE);
   assign bus_we     = (state_q == ST_RESET);
   assign bus_addr   = addr_q;
   assign bus_wdata  = RST_WORD;
   assign done       = done_q;
   assign pass       = pass_q;
   assign fail       = fail_q;
   assign final_data = final_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R2
   AST_PASS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> $past(bus_req && !bus_we && bus_ack)); // R8
   AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(bus_req && bus_we && bus_ack && bus_wdata == RST_WORD)); // R9
   AST_BUDGET_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      poll_ack && budget_last |=> state_q != ST_POLL); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({pass, fail}) == 1); // R11

endmodule

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
   localparam int AW = 19;
   localparam int DW = 8;
   localparam int CW = 16;

   typedef struct {
      string    tag;
      bit       ok;
      int       reads;
      bit [7:0] fin;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          use_toggle = 1'b0;
   logic          is_erase = 1'b0;
   logic [DW-1:0] expect_data = '0;
   logic [AW-1:0] target_addr = '0;
   logic [CW-1:0] max_polls = '0;
   logic          bus_req, bus_we, done, pass, fail;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, final_data;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;

   always #4 clk = ~clk;

   flash_done_poller u_flash_done_poller (
      .clk(clk), .rst_n(rst_n), .start(start), .use_toggle(use_toggle),
      .is_erase(is_erase), .expect_data(expect_data), .target_addr(target_addr),
      .max_polls(max_polls), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .done(done), .pass(pass), .fail(fail), .final_data(final_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] rsp_q[$];
   exp_t          exp_q[$];
   logic [AW-1:0] cur_addr = '0;
   int tot_rd = 0, tot_wr = 0, bad_addr = 0, bad_wd = 0;
   int base_rd = 0, base_wr = 0, base_ba = 0, base_bw = 0;
   exp_t mon_e;

   task automatic chk(string req, string what, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // flash responder: one acknowledge per request, served at negedge
   always @(negedge clk) begin
      if (bus_req && !bus_ack) begin
         bus_ack = 1'b1;
         if (bus_addr !== cur_addr) bad_addr++;
         if (bus_we) begin
            tot_wr++;
            if (bus_wdata !== 8'hF0) bad_wd++;
         end else begin
            tot_rd++;
            bus_rdata = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
         end
      end else begin
         bus_ack = 1'b0;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk("R11", "unexpected done", 1, 0);
         end else begin
            mon_e = exp_q.pop_front();
            chk(mon_e.tag, "pass", int'(pass), int'(mon_e.ok));
            chk(mon_e.tag, "fail", int'(fail), int'(!mon_e.ok));
            chk(mon_e.tag, "read count", tot_rd - base_rd, mon_e.reads);
            chk("R9", "reset writes", tot_wr - base_wr, mon_e.ok ? 0 : 1);
            chk("R9", "reset write data errors", bad_wd - base_bw, 0);
            chk("R2", "address errors", bad_addr - base_ba, 0);
            if (mon_e.ok) chk("R8", "final byte", int'(final_data), int'(mon_e.fin));
         end
         base_rd = tot_rd; base_wr = tot_wr; base_ba = bad_addr; base_bw = bad_wd;
      end
   end

   task automatic run_op(string tag, bit tgl, bit er, bit [7:0] ed, bit [AW-1:0] a,
                         int mx, bit ok, int reads, bit [7:0] fin);
      exp_t e;
      e.tag = tag; e.ok = ok; e.reads = reads; e.fin = fin;
      exp_q.push_back(e);
      @(negedge clk);
      cur_addr    = a;
      use_toggle  = tgl;
      is_erase    = er;
      expect_data = ed;
      target_addr = a;
      max_polls   = CW'(mx);
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk("R11", "done width", int'(done), 0);
      chk("R11", "verdict held", int'(ok ? pass : fail), 1);
      rsp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "req in reset", int'(bus_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pass after reset", int'(pass), 0);
      chk("R1", "fail after reset", int'(fail), 0);
      chk("R1", "req after reset", int'(bus_req), 0);

      // R3: steady bit 6 on first pair
      rsp_q = '{8'h40, 8'h40, 8'h5A};
      run_op("R3", 1, 0, 8'h00, 19'h1_2345, 100, 1, 3, 8'h5A);
      // R4: toggling with bit 5 clear keeps polling
      rsp_q = '{8'h00, 8'h40, 8'h00, 8'h00, 8'h33};
      run_op("R4", 1, 0, 8'h00, 19'h2_0010, 100, 1, 5, 8'h33);
      // R5: error bit, then steady pair -> pass
      rsp_q = '{8'h00, 8'h60, 8'h20, 8'h20, 8'h12};
      run_op("R5", 1, 1, 8'h00, 19'h3_0F00, 100, 1, 5, 8'h12);
      // R5: error bit, then still toggling -> fail
      rsp_q = '{8'h00, 8'h60, 8'h20, 8'h60};
      run_op("R5", 1, 1, 8'h00, 19'h4_0001, 100, 0, 4, 8'h00);
      // R6: program, delayed match on bit 7
      rsp_q = '{8'h05, 8'h85, 8'h85};
      run_op("R6", 0, 0, 8'h85, 19'h5_1111, 100, 1, 3, 8'h85);
      // R6: erase expects 1 whatever expect_data says
      rsp_q = '{8'h00, 8'hFF, 8'hFF};
      run_op("R6", 0, 1, 8'h00, 19'h6_0000, 100, 1, 3, 8'hFF);
      // R7: error-flagged mismatch, then match -> pass
      rsp_q = '{8'hA0, 8'h00, 8'h11};
      run_op("R7", 0, 0, 8'h00, 19'h7_7777, 100, 1, 3, 8'h11);
      // R7: error-flagged mismatch, then mismatch -> fail
      rsp_q = '{8'hA0, 8'h80};
      run_op("R7", 0, 0, 8'h00, 19'h0_0ABC, 100, 0, 2, 8'h00);
      // R10: toggle budget of 4 never resolves
      rsp_q = '{8'h00, 8'h40, 8'h00, 8'h40};
      run_op("R10", 1, 0, 8'h00, 19'h1_0004, 4, 0, 4, 8'h00);
      // R10: data budget of 3 never resolves
      rsp_q = '{8'h00, 8'h00, 8'h00};
      run_op("R10", 0, 0, 8'h80, 19'h2_0003, 3, 0, 3, 8'h00);

      repeat (4) @(negedge clk);
      chk("R11", "no stray done", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule